// File: doc/BRIEF.md
# Vector Length Control Register Unit

This unit owns the vector length register of a register-file-based vector extension and answers the integer pipeline's control-register instructions aimed at it. Each request carries an operation code, a 12-bit register address, a source operand (a register value, or a 5-bit immediate for the immediate forms) and a destination register index. One cycle later the unit returns the value to write back, a write-enable for the destination register and the index of that register. The current length is always visible on `vl_o` so that the vector sequencer can read it.

Two addresses select the same physical length register. On the primary address a write hands back the new length after clamping, so one instruction both sets the length and reports it. On the alias address the unit behaves like an ordinary control register and hands back the length as it was before the write. The stored length is always the requested value capped at `MAX_VL`. The unit never picks a shorter length of its own. The configuration must satisfy `RF_LEN <= MAX_VL <= XLEN`, and elaboration stops with an error when it does not.

A small response machine drives the outputs. Its states are IDLE (no response), ANSWER (a claimed request completes, `rsp_valid` high) and DECLINE (the request was not for this unit, `rsp_not_mine` high). From any state, a valid claimed request moves the machine to ANSWER, a valid unclaimed request moves it to DECLINE, and a cycle with no request moves it to IDLE.

Top module: `vl_csr_unit`

## Requirements
- R1: The stored length is min(requested value, MAX_VL). When the requested value is MAX_VL or less it is stored exactly. `vl_o` never exceeds MAX_VL.
- R2: The operation codes are 001 swap, 010 set-bits, 011 clear-bits, and 101/110/111 the same three operations taking the zero-extended immediate as the source. On the primary address (default 0x8C0) the returned data is the new stored length.
- R3: On the alias address (default 0x8C1) the returned data is the length before the request, and the clamped new value is still stored.
- R4: When the destination index is 0, `rsp_wen` stays low and the length is still updated.
- R5: Set-bits stores clamp(VL | src) and clear-bits stores clamp(VL & ~src), on either address.
- R6: A set-bits or clear-bits request with a zero source leaves the length unchanged. Both addresses then return the current length.
- R7: After reset the length equals MAX_VL and no response is pending.
- R8: The response appears exactly one cycle after the request. A request issued in the next cycle sees the length written by the previous one.
- R9: A request to any other address, or with reserved operation code 000 or 100, raises `rsp_not_mine` for one cycle with no `rsp_valid` and no write-enable, and leaves the length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 12 | Control register address |
| req_rs1_val | input | XLEN | Register source operand |
| req_zimm | input | 5 | Immediate source operand |
| req_rd | input | 5 | Destination register index |
| rsp_valid | output | 1 | Claimed request completes |
| rsp_data | output | XLEN | Value for the destination register |
| rsp_rd | output | 5 | Destination register index of the response |
| rsp_wen | output | 1 | Destination register write-enable |
| rsp_not_mine | output | 1 | Request was not for this unit |
| vl_o | output | $clog2(XLEN+1) | Current vector length |

## Verification
The bench builds the unit with XLEN=32, RF_LEN=8 and MAX_VL=20. The limit of 20 lies below the largest 5-bit immediate (31), so clamping can be reached from both the register and the immediate forms. Set-bits operations can also produce values above the limit (for example 10|16=26). The small width keeps the expected values easy to work out by hand, while the old-versus-new return rule stays visible on both addresses.

// File: rtl/vl_csr_pkg.sv
package vl_csr_pkg;

    localparam int CSR_ADDR_W = 12;
    localparam int REG_IDX_W  = 5;
    localparam int IMM_W      = 5;

    typedef enum logic [2:0] {
        OP_RSVD0 = 3'b000,
        OP_SWAP  = 3'b001,
        OP_SET   = 3'b010,
        OP_CLR   = 3'b011,
        OP_RSVD4 = 3'b100,
        OP_SWAPI = 3'b101,
        OP_SETI  = 3'b110,
        OP_CLRI  = 3'b111
    } csr_op_e;

    typedef enum logic [1:0] {
        MOD_WRITE = 2'd0,
        MOD_SET   = 2'd1,
        MOD_CLEAR = 2'd2
    } modify_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ANSWER  = 2'd1,
        ST_DECLINE = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/vl_csr_decode.sv
module vl_csr_decode
    import vl_csr_pkg::*;
#(
    parameter logic [CSR_ADDR_W-1:0] PRIMARY_ADDR = 12'h8C0,
    parameter logic [CSR_ADDR_W-1:0] ALIAS_ADDR   = 12'h8C1
) (
    input  logic [2:0]            op,
    input  logic [CSR_ADDR_W-1:0] addr,
    output logic                  claimed,
    output logic                  is_alias,
    output logic                  use_imm,
    output modify_e               kind
);
    logic op_ok;
    logic hit_primary;
    logic hit_alias;

    assign hit_primary = (addr == PRIMARY_ADDR);
    assign hit_alias   = (addr == ALIAS_ADDR);

    always_comb begin
        op_ok   = 1'b1;
        use_imm = 1'b0;
        kind    = MOD_WRITE;
        unique case (csr_op_e'(op))
            OP_SWAP:  kind = MOD_WRITE;
            OP_SET:   kind = MOD_SET;
            OP_CLR:   kind = MOD_CLEAR;
            OP_SWAPI: begin kind = MOD_WRITE; use_imm = 1'b1; end
            OP_SETI:  begin kind = MOD_SET;   use_imm = 1'b1; end
            OP_CLRI:  begin kind = MOD_CLEAR; use_imm = 1'b1; end
            OP_RSVD0, OP_RSVD4: op_ok = 1'b0;
            default:  op_ok = 1'b0;
        endcase
    end

    assign claimed  = (hit_primary || hit_alias) && op_ok;
    assign is_alias = hit_alias;

endmodule

// File: rtl/vl_clamp.sv
module vl_clamp #(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(XLEN + 1)
) (
    input  logic [XLEN-1:0] raw,
    output logic [VL_W-1:0] capped
);
    localparam logic [XLEN-1:0] LIMIT_X = XLEN'(MAX_VL);
    localparam logic [VL_W-1:0] LIMIT_V = VL_W'(MAX_VL);

    always_comb begin
        if (raw > LIMIT_X) capped = LIMIT_V;
        else               capped = raw[VL_W-1:0];
    end

endmodule

// File: rtl/vl_csr_update.sv
module vl_csr_update
    import vl_csr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 64,
    parameter int VL_W   = $clog2(XLEN + 1)
) (
    input  logic [VL_W-1:0] cur_vl,
    input  logic [XLEN-1:0] src,
    input  modify_e         kind,
    input  logic            is_alias,
    output logic            do_write,
    output logic [VL_W-1:0] next_vl,
    output logic [XLEN-1:0] ret_val
);
    logic [XLEN-1:0] cur_x;
    logic [XLEN-1:0] raw;
    logic [VL_W-1:0] capped;

    assign cur_x = XLEN'(cur_vl);

    always_comb begin
        unique case (kind)
            MOD_WRITE: raw = src;
            MOD_SET:   raw = cur_x | src;
            MOD_CLEAR: raw = cur_x & ~src;
            default:   raw = src;
        endcase
    end

    vl_clamp #(
        .XLEN   (XLEN),
        .MAX_VL (MAX_VL),
        .VL_W   (VL_W)
    ) u_clamp (
        .raw    (raw),
        .capped (capped)
    );

    // a set or clear with nothing to set or clear is a pure read
    assign do_write = (kind == MOD_WRITE) || (src != '0);
    assign next_vl  = do_write ? capped : cur_vl;
    assign ret_val  = is_alias ? cur_x : XLEN'(next_vl);

endmodule

// File: rtl/vl_csr_unit.sv
module vl_csr_unit
    import vl_csr_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int RF_LEN = 32,
    parameter int MAX_VL = 64,
    parameter logic [CSR_ADDR_W-1:0] PRIMARY_ADDR = 12'h8C0,
    parameter logic [CSR_ADDR_W-1:0] ALIAS_ADDR   = 12'h8C1,
    localparam int VL_W = $clog2(XLEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [CSR_ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]       req_rs1_val,
    input  logic [IMM_W-1:0]      req_zimm,
    input  logic [REG_IDX_W-1:0]  req_rd,
    output logic                  rsp_valid,
    output logic [XLEN-1:0]       rsp_data,
    output logic [REG_IDX_W-1:0]  rsp_rd,
    output logic                  rsp_wen,
    output logic                  rsp_not_mine,
    output logic [VL_W-1:0]       vl_o
);
    if (RF_LEN < 1 || RF_LEN > MAX_VL || MAX_VL > XLEN) begin : g_cfg_bad
        $error("vl_csr_unit: need 1 <= RF_LEN <= MAX_VL <= XLEN");
    end

    rsp_state_e state_q, state_d;

    logic                 claimed;
    logic                 is_alias;
    logic                 use_imm;
    modify_e              kind;
    logic [XLEN-1:0]      src;
    logic                 do_write;
    logic [VL_W-1:0]      next_vl;
    logic [XLEN-1:0]      ret_val;

    logic [VL_W-1:0]      vl_q;
    logic [XLEN-1:0]      data_q;
    logic [REG_IDX_W-1:0] rd_q;
    logic                 wen_q;

    vl_csr_decode #(
        .PRIMARY_ADDR (PRIMARY_ADDR),
        .ALIAS_ADDR   (ALIAS_ADDR)
    ) u_decode (
        .op       (req_op),
        .addr     (req_addr),
        .claimed  (claimed),
        .is_alias (is_alias),
        .use_imm  (use_imm),
        .kind     (kind)
    );

    assign src = use_imm ? XLEN'(req_zimm) : req_rs1_val;

    vl_csr_update #(
        .XLEN   (XLEN),
        .MAX_VL (MAX_VL),
        .VL_W   (VL_W)
    ) u_update (
        .cur_vl   (vl_q),
        .src      (src),
        .kind     (kind),
        .is_alias (is_alias),
        .do_write (do_write),
        .next_vl  (next_vl),
        .ret_val  (ret_val)
    );

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_ANSWER, ST_DECLINE: begin
                if (req_valid) state_d = claimed ? ST_ANSWER : ST_DECLINE;
                else           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // length register and captured response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q   <= VL_W'(MAX_VL);
            data_q <= '0;
            rd_q   <= '0;
            wen_q  <= 1'b0;
        end else if (req_valid && claimed) begin
            if (do_write) vl_q <= next_vl;
            data_q <= ret_val;
            rd_q   <= req_rd;
            wen_q  <= (req_rd != '0);
        end
    end

    // outputs by state
    always_comb begin
        rsp_valid    = 1'b0;
        rsp_data     = '0;
        rsp_rd       = '0;
        rsp_wen      = 1'b0;
        rsp_not_mine = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ANSWER: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
                rsp_rd    = rd_q;
                rsp_wen   = wen_q;
            end
            ST_DECLINE: rsp_not_mine = 1'b1;
            default: ;
        endcase
    end

    assign vl_o = vl_q;

endmodule

// File: rtl/vl_csr_unit_chk.sv
module vl_csr_unit_chk #(
    parameter int XLEN   = 64,
    parameter int MAX_VL = 64,
    parameter logic [11:0] PRIMARY_ADDR = 12'h8C0,
    parameter logic [11:0] ALIAS_ADDR   = 12'h8C1,
    parameter int VL_W = $clog2(XLEN + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic [11:0]     req_addr,
    input logic [4:0]      req_rd,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_data,
    input logic            rsp_wen,
    input logic            rsp_not_mine,
    input logic [VL_W-1:0] vl_o
);
    logic op_ok, to_primary, to_alias;
    assign op_ok      = (req_op[1:0] != 2'b00);
    assign to_primary = req_valid && op_ok && (req_addr == PRIMARY_ADDR);
    assign to_alias   = req_valid && op_ok && (req_addr == ALIAS_ADDR);

    // R1
    vl_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vl_o <= VL_W'(MAX_VL));

    // R2
    primary_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_primary |=> rsp_data == XLEN'(vl_o));

    // R3
    alias_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_alias |=> rsp_data == XLEN'($past(vl_o)));

    // R4
    x0_no_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rd == 5'd0) |=> !rsp_wen);

    // R8
    answer_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_primary || to_alias) |=> (rsp_valid && !rsp_not_mine));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_not_mine && $stable(vl_o)));

    // R9
    decline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !to_primary && !to_alias)
            |=> (rsp_not_mine && !rsp_valid && !rsp_wen && $stable(vl_o)));

endmodule

bind vl_csr_unit vl_csr_unit_chk #(
    .XLEN         (XLEN),
    .MAX_VL       (MAX_VL),
    .PRIMARY_ADDR (PRIMARY_ADDR),
    .ALIAS_ADDR   (ALIAS_ADDR),
    .VL_W         (VL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .req_rd       (req_rd),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_wen      (rsp_wen),
    .rsp_not_mine (rsp_not_mine),
    .vl_o         (vl_o)
);

// File: tb/tb_vl_csr_unit.sv
`timescale 1ns/1ps
module tb_vl_csr_unit;
    localparam int XLEN = 32;
    localparam int RFL  = 8;
    localparam int MAXV = 20;
    localparam int VW   = $clog2(XLEN + 1);
    localparam logic [11:0] PA = 12'h8C0;
    localparam logic [11:0] AA = 12'h8C1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = '0;
    logic [11:0]     req_addr = '0;
    logic [XLEN-1:0] req_rs1_val = '0;
    logic [4:0]      req_zimm = '0;
    logic [4:0]      req_rd = '0;
    logic            rsp_valid;
    logic [XLEN-1:0] rsp_data;
    logic [4:0]      rsp_rd;
    logic            rsp_wen;
    logic            rsp_not_mine;
    logic [VW-1:0]   vl_o;

    always #4 clk = ~clk;

    vl_csr_unit #(.XLEN(XLEN), .RF_LEN(RFL), .MAX_VL(MAXV),
                  .PRIMARY_ADDR(PA), .ALIAS_ADDR(AA)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_rs1_val(req_rs1_val), .req_zimm(req_zimm),
        .req_rd(req_rd), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_rd(rsp_rd), .rsp_wen(rsp_wen), .rsp_not_mine(rsp_not_mine),
        .vl_o(vl_o));

    typedef struct {
        int          due;
        logic        nm;
        logic [31:0] data;
        logic        wen;
        logic [4:0]  rd;
        int          vl_after;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    int   model_vl = MAXV;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic fail(input string tag, input string what, input int act, input int exp);
        n_bad++;
        $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    endtask

    task automatic apply(input logic [2:0] op, input logic [11:0] addr,
                         input int src, input int zimm, input int rd, input string tag);
        exp_t e;
        int srcv, raw, newv, ret;
        bit claimed, wr;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_rs1_val = src; req_zimm = 5'(zimm); req_rd = 5'(rd);
        claimed = (addr == PA || addr == AA) && (op[1:0] != 2'b00);
        srcv = op[2] ? zimm : src;
        case (op[1:0])
            2'd1:    raw = srcv;
            2'd2:    raw = model_vl | srcv;
            default: raw = model_vl & ~srcv;
        endcase
        wr   = claimed && (op[1:0] == 2'd1 || srcv != 0);
        newv = wr ? ((raw > MAXV) ? MAXV : raw) : model_vl;
        ret  = (addr == AA) ? model_vl : newv;
        e.due = cyc + 1; e.nm = !claimed; e.data = claimed ? ret : 0;
        e.wen = claimed && rd != 0; e.rd = claimed ? 5'(rd) : 5'd0;
        e.vl_after = newv; e.tag = tag;
        q.push_back(e);
        model_vl = newv;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // monitor: compare each due item, flag anything unexpected
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (rsp_valid !== !e.nm)   fail(e.tag, "rsp_valid", rsp_valid, !e.nm);
                if (rsp_not_mine !== e.nm) fail(e.tag, "rsp_not_mine", rsp_not_mine, e.nm);
                if (rsp_data !== e.data)   fail(e.tag, "rsp_data", rsp_data, e.data);
                if (rsp_wen !== e.wen)     fail(e.tag, "rsp_wen", rsp_wen, e.wen);
                if (rsp_rd !== e.rd)       fail(e.tag, "rsp_rd", rsp_rd, e.rd);
                if (int'(vl_o) != e.vl_after) fail(e.tag, "vl_o", vl_o, e.vl_after);
            end else if (rsp_valid || rsp_not_mine) begin
                fail("R8", "unexpected response", 1, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (vl_o !== VW'(MAXV)) fail("R7", "vl_o in reset", vl_o, MAXV);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (vl_o !== VW'(MAXV) || rsp_valid !== 1'b0)
            fail("R7", "vl_o after reset", vl_o, MAXV);

        apply(3'b001, PA, 5, 0, 3, "R1 exact");        idle(1);
        apply(3'b001, PA, 100, 0, 3, "R1 clamp");      idle(1);
        apply(3'b101, PA, 0, 31, 7, "R2 imm clamp");   idle(1);
        apply(3'b101, PA, 0, 8, 7, "R2 imm exact");    idle(1);
        apply(3'b001, AA, 12, 0, 4, "R3 alias old");   idle(1);
        apply(3'b001, AA, 1000, 0, 4, "R3 alias clamp"); idle(1);
        apply(3'b001, PA, 8, 0, 0, "R4 x0 write");     idle(1);
        apply(3'b010, AA, 0, 0, 1, "R6 alias read");   idle(1);
        apply(3'b010, PA, 3, 0, 2, "R5 set");          idle(1);
        apply(3'b011, PA, 1, 0, 2, "R5 clear");        idle(1);
        apply(3'b110, AA, 0, 16, 9, "R5 seti clamp");  idle(1);
        apply(3'b111, PA, 0, 0, 9, "R6 primary read"); idle(1);
        apply(3'b011, AA, 0, 0, 9, "R6 alias clr0");   idle(1);
        apply(3'b001, 12'h300, 3, 0, 5, "R9 other addr"); idle(1);
        apply(3'b000, PA, 3, 0, 5, "R9 rsvd op");      idle(1);
        apply(3'b001, PA, 4, 0, 6, "R8 first");
        apply(3'b010, AA, 1, 0, 6, "R8 second");
        apply(3'b001, 12'h123, 9, 0, 6, "R9 between");
        apply(3'b011, PA, 4, 0, 0, "R8 third");
        idle(4);

        n_vec++;
        if (q.size() != 0) fail("R8", "pending responses", q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule